// File: doc/BRIEF.md
# Redundant Reference Clock Guard

The guard watches a primary and a secondary reference clock from a separate monitoring clock, `mon_clk`. The monitoring period is modelled as a window of `FB_DIV` cycles of `mon_clk`. Each reference is brought into the `mon_clk` domain through a two-stage synchronizer, and its edges are detected there.

A reference that shows no edge for a whole window has stopped toggling, either held high or held low. Its loss flag rises. The flag clears only after edges have been seen in two windows in a row. When the primary is lost and the secondary is healthy, the selection moves to the secondary. As soon as the primary is healthy again, the selection returns to it with no outside command.

A glitch-free multiplexer drives `clk_out` from the selected reference. It uses two cross-coupled enable chains, each clocked on the falling edge of its own reference. A chain is cleared at once while its reference is flagged lost, so a dead clock can never stall a switch.

Each reference has a health machine with three states:
- HL_GOOD. It moves to HL_LOST at a window end with no edge.
- HL_LOST. It moves to HL_RECOVER at a window end with an edge.
- HL_RECOVER. It moves to HL_GOOD at a window end with an edge, and falls back to HL_LOST at a window end without one.

The selector has two states:
- SEL_PRI. It moves to SEL_SEC when the primary is lost and the secondary is not.
- SEL_SEC. It returns to SEL_PRI when the primary is no longer lost, or when the secondary is lost too.

Top module: `refclk_guard`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `lost_pri` = 0, `lost_sec` = 0 and `ref_active` = 0, where 0 means primary and 1 means secondary.
- R2: Loss detection works as follows:
  - A reference held high or held low raises its loss flag no later than 2*FB_DIV+6 `mon_clk` cycles after it stops.
  - Flags change only on the `mon_clk` edge that ends a window, which is every FB_DIV cycles counted from reset.
  - An input transition counts as an edge two cycles after the cycle in which it was sampled.
- R3: A lost reference that resumes keeps its flag high for at least the first 8 cycles. Its flag clears only after two consecutive windows that each contain an edge.
- R4: When `lost_pri` = 1 and `lost_sec` = 0 in a cycle, `ref_active` = 1 in the next cycle.
- R5: When `lost_pri` = 0 in a cycle, `ref_active` = 0 in the next cycle. Return to the primary is automatic.
- R6: Loss of the secondary while the primary is selected raises `lost_sec` only. `ref_active` stays 0 and `clk_out` keeps following the primary.
- R7: When both flags are high, `ref_active` = 0 in the next cycle.
- R8: Once the selection has been stable for several windows, `clk_out` equals the selected reference. This holds even when the unselected reference is stopped high.
- R9: No high or low pulse on `clk_out` is shorter than half the shorter reference period. The two enables are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Monitoring clock; FB_DIV cycles form one window |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pri | input | 1 | Primary reference clock |
| ref_sec | input | 1 | Secondary reference clock |
| lost_pri | output | 1 | High while the primary is lost or recovering |
| lost_sec | output | 1 | High while the secondary is lost or recovering |
| ref_active | output | 1 | Selected input: 0 primary, 1 secondary |
| clk_out | output | 1 | Glitch-free multiplexed reference clock |

## Verification
The flags are registered on the `mon_clk` edge that closes a window. That edge uses edge information that is two samples old. `ref_active` is registered one cycle after the flags.

The bench keeps a behavioural model of windows, edge history and selection. It advances the model on each rising edge and compares it with the ports on the following falling edge, so every cycle is checked at the exact cycle where each result is due.

The directed checks sample well past the worst-case latencies. Flags and selection are checked 2*FB_DIV+6 cycles after a stop. Restoration is checked after 8 cycles, where the flag must still be high, and again after 3*FB_DIV+8 cycles, where it must be clear. The checks of `clk_out` wait ten windows for the enable chains to settle. Pulse widths are measured in absolute time on every `clk_out` transition.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
    typedef enum logic [1:0] {
        HL_GOOD    = 2'd0,
        HL_LOST    = 2'd1,
        HL_RECOVER = 2'd2
    } health_t;

    typedef enum logic {
        SEL_PRI = 1'b0,
        SEL_SEC = 1'b1
    } sel_t;

    localparam int NUM_REFS = 2;
endpackage

// File: rtl/rcg_window.sv
module rcg_window #(
    parameter int FB_DIV = 16
) (
    input  logic mon_clk,
    input  logic rst_n,
    output logic win_end
);
    localparam int CW = (FB_DIV > 1) ? $clog2(FB_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(FB_DIV - 1);

    logic [CW-1:0] cnt;

    // A window closes on the edge where the counter sits at its last value.
    assign win_end = (cnt == LAST);

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (win_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/rcg_health.sv
module rcg_health
    import rcg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic win_end,
    output logic lost
);
    logic [SYNC_STAGES:0] shift_q;
    logic                 edge_seen;
    logic                 seen_q;
    logic                 win_active;
    health_t              state_q;
    health_t              state_d;

    // Synchronizer stages plus one more stage used to compare for an edge.
    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
        end else begin
            shift_q <= {shift_q[SYNC_STAGES-1:0], ref_in};
        end
    end

    assign edge_seen  = shift_q[SYNC_STAGES] ^ shift_q[SYNC_STAGES-1];
    assign win_active = seen_q | edge_seen;

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (win_end) begin
            seen_q <= 1'b0;
        end else if (edge_seen) begin
            seen_q <= 1'b1;
        end
    end

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HL_GOOD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (win_end) begin
            unique case (state_q)
                HL_GOOD:    state_d = win_active ? HL_GOOD    : HL_LOST;
                HL_LOST:    state_d = win_active ? HL_RECOVER : HL_LOST;
                HL_RECOVER: state_d = win_active ? HL_GOOD    : HL_LOST;
                default:    state_d = HL_LOST;
            endcase
        end
    end

    always_comb begin
        lost = (state_q != HL_GOOD);
    end
endmodule

// File: rtl/rcg_select.sv
module rcg_select
    import rcg_pkg::*;
(
    input  logic mon_clk,
    input  logic rst_n,
    input  logic lost_pri,
    input  logic lost_sec,
    output logic use_sec
);
    sel_t state_q;
    sel_t state_d;

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEL_PRI;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_PRI: if (lost_pri && !lost_sec) state_d = SEL_SEC;
            SEL_SEC: if (!lost_pri || lost_sec) state_d = SEL_PRI;
            default: state_d = SEL_PRI;
        endcase
    end

    always_comb begin
        use_sec = (state_q == SEL_SEC);
    end
endmodule

// File: rtl/rcg_mux.sv
module rcg_mux (
    input  logic rst_n,
    input  logic ref_pri,
    input  logic ref_sec,
    input  logic kill_pri,
    input  logic kill_sec,
    input  logic use_sec,
    output logic en_pri,
    output logic en_sec,
    output logic clk_out
);
    logic clr_pri_n;
    logic clr_sec_n;
    logic pri_q0, pri_q1;
    logic sec_q0, sec_q1;

    // A lost reference cannot clock its own chain, so it is cleared directly.
    assign clr_pri_n = rst_n & ~kill_pri;
    assign clr_sec_n = rst_n & ~kill_sec;

    always_ff @(negedge ref_pri or negedge clr_pri_n) begin
        if (!clr_pri_n) begin
            pri_q0 <= 1'b0;
            pri_q1 <= 1'b0;
        end else begin
            pri_q0 <= ~use_sec & ~(sec_q0 | sec_q1);
            pri_q1 <= pri_q0;
        end
    end

    always_ff @(negedge ref_sec or negedge clr_sec_n) begin
        if (!clr_sec_n) begin
            sec_q0 <= 1'b0;
            sec_q1 <= 1'b0;
        end else begin
            sec_q0 <= use_sec & ~(pri_q0 | pri_q1);
            sec_q1 <= sec_q0;
        end
    end

    assign en_pri  = pri_q1;
    assign en_sec  = sec_q1;
    assign clk_out = (ref_pri & pri_q1) | (ref_sec & sec_q1);
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
    import rcg_pkg::*;
#(
    parameter int FB_DIV      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic ref_pri,
    input  logic ref_sec,
    output logic lost_pri,
    output logic lost_sec,
    output logic ref_active,
    output logic clk_out
);
    logic                win_end;
    logic [NUM_REFS-1:0] refs;
    logic [NUM_REFS-1:0] lost_vec;
    logic                use_sec;
    logic                en_pri;
    logic                en_sec;

    assign refs = {ref_sec, ref_pri};

    rcg_window #(.FB_DIV(FB_DIV)) u_window (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .win_end (win_end)
    );

    for (genvar gi = 0; gi < NUM_REFS; gi++) begin : g_health
        rcg_health #(.SYNC_STAGES(SYNC_STAGES)) u_health (
            .mon_clk (mon_clk),
            .rst_n   (rst_n),
            .ref_in  (refs[gi]),
            .win_end (win_end),
            .lost    (lost_vec[gi])
        );
    end

    rcg_select u_select (
        .mon_clk  (mon_clk),
        .rst_n    (rst_n),
        .lost_pri (lost_vec[0]),
        .lost_sec (lost_vec[1]),
        .use_sec  (use_sec)
    );

    rcg_mux u_mux (
        .rst_n    (rst_n),
        .ref_pri  (ref_pri),
        .ref_sec  (ref_sec),
        .kill_pri (lost_vec[0]),
        .kill_sec (lost_vec[1]),
        .use_sec  (use_sec),
        .en_pri   (en_pri),
        .en_sec   (en_sec),
        .clk_out  (clk_out)
    );

    assign lost_pri   = lost_vec[0];
    assign lost_sec   = lost_vec[1];
    assign ref_active = use_sec;
endmodule

// File: rtl/rcg_checker.sv
module rcg_checker (
    input logic mon_clk,
    input logic rst_n,
    input logic win_end,
    input logic lost_pri,
    input logic lost_sec,
    input logic ref_active,
    input logic en_pri,
    input logic en_sec
);
    assert_flags_hold_R2: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !win_end |=> ($stable(lost_pri) && $stable(lost_sec)));

    assert_failover_R4: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (lost_pri && !lost_sec) |=> ref_active);

    assert_revert_R5: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !lost_pri |=> !ref_active);

    assert_both_lost_R7: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (lost_pri && lost_sec) |=> !ref_active);

    assert_enables_excl_R9: assert property (@(posedge mon_clk) disable iff (!rst_n)
        !(en_pri && en_sec));
endmodule

bind refclk_guard rcg_checker u_chk (
    .mon_clk    (mon_clk),
    .rst_n      (rst_n),
    .win_end    (win_end),
    .lost_pri   (lost_pri),
    .lost_sec   (lost_sec),
    .ref_active (ref_active),
    .en_pri     (en_pri),
    .en_sec     (en_sec)
);

// File: tb/refclk_guard_test.sv
`timescale 1ns/1ps
module refclk_guard_test;
    localparam int FB_DIV = 16;

    logic mon_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic ref_pri = 1'b0;
    logic ref_sec = 1'b0;
    logic run_pri = 1'b1, hold_pri = 1'b0;
    logic run_sec = 1'b1, hold_sec = 1'b0;
    logic lost_pri, lost_sec, ref_active, clk_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    refclk_guard #(.FB_DIV(FB_DIV), .SYNC_STAGES(2)) uut (
        .mon_clk    (mon_clk),
        .rst_n      (rst_n),
        .ref_pri    (ref_pri),
        .ref_sec    (ref_sec),
        .lost_pri   (lost_pri),
        .lost_sec   (lost_sec),
        .ref_active (ref_active),
        .clk_out    (clk_out)
    );

    always #2 mon_clk = ~mon_clk;

    // References on an odd-nanosecond grid, never at a mon_clk edge.
    initial begin
        #1;
        forever begin
            #12;
            ref_pri = run_pri ? ~ref_pri : hold_pri;
        end
    end
    initial begin
        #1;
        forever begin
            #14;
            ref_sec = run_sec ? ~ref_sec : hold_sec;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural model: window count, 3-sample history, health level, selection.
    int         m_cnt = 0;
    int         m_h [2];
    bit         m_seen [2];
    logic [2:0] m_hist [2];
    bit         m_sel = 1'b0;
    bit         m_we, m_f0, m_f1, m_ed, m_any;

    always @(posedge mon_clk) begin
        if (!rst_n) begin
            m_cnt = 0;
            m_sel = 1'b0;
            for (int i = 0; i < 2; i++) begin
                m_h[i] = 0; m_seen[i] = 1'b0; m_hist[i] = 3'b000;
            end
        end else begin
            m_we = (m_cnt == FB_DIV - 1);
            m_f0 = (m_h[0] != 0);
            m_f1 = (m_h[1] != 0);
            for (int i = 0; i < 2; i++) begin
                m_ed = m_hist[i][1] ^ m_hist[i][2];
                if (m_we) begin
                    m_any = m_seen[i] | m_ed;
                    if (m_h[i] == 0)      m_h[i] = m_any ? 0 : 1;
                    else if (m_h[i] == 1) m_h[i] = m_any ? 2 : 1;
                    else                  m_h[i] = m_any ? 0 : 1;
                    m_seen[i] = 1'b0;
                end else begin
                    m_seen[i] = m_seen[i] | m_ed;
                end
                m_hist[i] = {m_hist[i][1:0], (i == 0) ? ref_pri : ref_sec};
            end
            m_sel = m_f0 && !m_f1;
            m_cnt = m_we ? 0 : m_cnt + 1;
        end
    end

    always @(negedge mon_clk) begin
        if (rst_n && !done) begin
            check(lost_pri === (m_h[0] != 0), "R2/R3", "model lost_pri", int'(lost_pri), int'(m_h[0] != 0));
            check(lost_sec === (m_h[1] != 0), "R2/R3", "model lost_sec", int'(lost_sec), int'(m_h[1] != 0));
            check(ref_active === m_sel, "R4/R5/R6/R7", "model ref_active", int'(ref_active), int'(m_sel));
        end
    end

    // Pulse width monitor on clk_out (R9).
    bit      mon_on = 1'b0;
    realtime last_t = 0.0;
    realtime min_hi = 1.0e9;
    realtime min_lo = 1.0e9;
    always @(clk_out) begin
        if (mon_on) begin
            if (clk_out === 1'b0 && ($realtime - last_t) < min_hi) min_hi = $realtime - last_t;
            if (clk_out === 1'b1 && ($realtime - last_t) < min_lo) min_lo = $realtime - last_t;
        end
        last_t = $realtime;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge mon_clk);
    endtask

    task automatic check_follow(input bit want_sec, input string req);
        int bad = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge mon_clk);
            if (clk_out !== (want_sec ? ref_sec : ref_pri)) bad++;
        end
        check(bad == 0, req, "clk_out mismatches vs selected ref", bad, 0);
    endtask

    task automatic stop_ref(input bit sec, input bit level);
        if (sec) begin hold_sec = level; run_sec = 1'b0; end
        else     begin hold_pri = level; run_pri = 1'b0; end
    endtask

    task automatic restart_ref(input bit sec);
        if (sec) run_sec = 1'b1; else run_pri = 1'b1;
    endtask

    task automatic fail_primary(input bit level);
        stop_ref(1'b0, level);
        wait_cyc(2 * FB_DIV + 6);
        check(lost_pri === 1'b1, "R2", "lost_pri after primary stop", int'(lost_pri), 1);
        check(lost_sec === 1'b0, "R2", "lost_sec stays low", int'(lost_sec), 0);
        check(ref_active === 1'b1, "R4", "switch to secondary", int'(ref_active), 1);
        wait_cyc(10 * FB_DIV);
        check_follow(1'b1, "R8");
        restart_ref(1'b0);
        wait_cyc(8);
        check(lost_pri === 1'b1, "R3", "flag held early in restore", int'(lost_pri), 1);
        wait_cyc(3 * FB_DIV);
        check(lost_pri === 1'b0, "R3", "flag cleared after two windows", int'(lost_pri), 0);
        check(ref_active === 1'b0, "R5", "automatic return to primary", int'(ref_active), 0);
        wait_cyc(10 * FB_DIV);
        check_follow(1'b0, "R5");
    endtask

    task automatic fail_secondary(input bit level);
        stop_ref(1'b1, level);
        wait_cyc(2 * FB_DIV + 6);
        check(lost_sec === 1'b1, "R6", "lost_sec after secondary stop", int'(lost_sec), 1);
        check(lost_pri === 1'b0, "R6", "lost_pri stays low", int'(lost_pri), 0);
        check(ref_active === 1'b0, "R6", "selection unchanged", int'(ref_active), 0);
        check_follow(1'b0, "R6");
        restart_ref(1'b1);
        wait_cyc(4 * FB_DIV);
        check(lost_sec === 1'b0, "R3", "secondary restored", int'(lost_sec), 0);
    endtask

    initial begin
        #1;
        check(lost_pri === 1'b0 && lost_sec === 1'b0 && ref_active === 1'b0, "R1",
              "outputs in reset", int'({lost_pri, lost_sec, ref_active}), 0);
        wait_cyc(10);
        #1 rst_n = 1'b1;
        wait_cyc(1);
        check(lost_pri === 1'b0 && lost_sec === 1'b0 && ref_active === 1'b0, "R1",
              "outputs after reset", int'({lost_pri, lost_sec, ref_active}), 0);
        wait_cyc(10 * FB_DIV);
        check(lost_pri === 1'b0 && lost_sec === 1'b0, "R2", "no loss with both running",
              int'({lost_pri, lost_sec}), 0);
        check_follow(1'b0, "R8");
        mon_on = 1'b1;

        fail_primary(1'b1);
        fail_primary(1'b0);
        fail_secondary(1'b1);
        fail_secondary(1'b0);

        // Both references lost.
        stop_ref(1'b0, 1'b1);
        wait_cyc(2 * FB_DIV + 6);
        check(ref_active === 1'b1, "R4", "on secondary before second loss", int'(ref_active), 1);
        stop_ref(1'b1, 1'b0);
        wait_cyc(2 * FB_DIV + 6);
        check(lost_pri === 1'b1 && lost_sec === 1'b1, "R7", "both flags high",
              int'({lost_pri, lost_sec}), 3);
        check(ref_active === 1'b0, "R7", "both lost selects primary", int'(ref_active), 0);
        restart_ref(1'b0);
        restart_ref(1'b1);
        wait_cyc(4 * FB_DIV);
        check(lost_pri === 1'b0 && lost_sec === 1'b0 && ref_active === 1'b0, "R5",
              "recovered from double loss", int'({lost_pri, lost_sec, ref_active}), 0);
        wait_cyc(10 * FB_DIV);
        check_follow(1'b0, "R8");

        check(min_hi >= 11.9, "R9", "min high pulse ps", int'(min_hi * 1000.0), 12000);
        check(min_lo >= 11.9, "R9", "min low pulse ps", int'(min_lo * 1000.0), 12000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule